// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block models a small serial EEPROM that a host drives over two lines, a clock line and a data line. Both lines are registered on the system clock. The block watches the registered lines for changes. A falling data line while the clock line stays high starts a transfer. A rising data line while the clock line stays high ends it. While a transfer is open, every rising clock-line edge advances a cycle counter. Every falling clock-line edge captures a bit.

The block answers in one of three framings, selected by `mode_i`:
- **Legacy (`00`).** One command byte carries a 7-bit byte index and the read/write flag.
- **Short (`01`).** A device byte is followed by one address byte. The device byte supplies three high address bits.
- **Long (`10` or `11`).** A device byte is followed by two address bytes, giving a 13-bit address.

The block drives its data-out bit low in acknowledge slots and supplies stored bits during reads. At all other times the data-out bit repeats the sampled data line.

A host that holds the clock line low for long enough receives the next bit early. A sticky flag reports that storage has been written.

Top module: `twowire_eeprom`

## Requirements
- R1: A synchronous reset clears the transfer state and the write flag (`changed_o` = 0). After reset, `sda_o` repeats the sampled `sda_i`. Stored bytes are kept through reset.
- R2: A start is a 1→0 data change with the clock line high. A stop is a 0→1 data change with the clock line high. Outside a transfer, `sda_o` equals `sda_i` delayed by one clock, and clock pulses write nothing.
- R3: In cycles 9, 18 and 27 of a transfer, `sda_o` is 0.
- R4: In legacy mode, the first byte is sent MSB first as {index[6:0], rw}, where rw = 1 means read. Each data byte of a write is shifted MSB first into the indexed byte.
- R5: In a legacy write, the index advances after each byte, but only index bits [1:0] change. The writes therefore wrap inside an aligned group of 4 bytes.
- R6: In a legacy read, bits are presented MSB first while the clock line is high in cycles 10..17. After each byte the index advances by one, modulo 128.
- R7: In short mode, the device byte is {4'b1010, blk[2:0], rw}. The byte address is {blk, addrbyte}, 11 bits.
- R8: In long mode, the byte address is {hi, lo} masked to 13 bits, with the high byte sent first. Storage uses the low MEM_AW address bits (default 9).
- R9: In short and long writes, the address advances after each byte, but only address bits [3:0] change, giving a 16-byte page wrap.
- R10: In short and long reads, the full address advances after each byte. Sequential reads therefore cross 16-byte and MEM_AW boundaries.
- R11: The clock line may be low with both lines unchanged for at least EARLY_CLKS clocks. In that case `sda_o` already shows the bit of the next cycle: the ack 0 or the next read bit.
- R12: `changed_o` rises on the first stored bit and stays high until reset. Transfers that only set an address or read leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Framing: 00 legacy, 01 short, 1x long |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level from host |
| sda_o | output | 1 | Data bit driven towards the host |
| changed_o | output | 1 | Sticky storage-written flag |

## Verification
A line change reaches the input register on the next clock edge. The cycle counter, address and flags take it one edge later. `sda_o` is combinational from those registers, so it settles two clocks after the change. The early-read response needs EARLY_CLKS further quiet clocks.

The bench holds every line level for four clocks. It samples `sda_o` and `changed_o` on the falling clock edge at the end of that hold, well after both registers have taken the change. The early-read checks hold the clock line low for forty clocks before sampling.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int CYC_W  = 6;
    localparam int ADDR_W = 13;

    localparam logic [1:0] MODE_LEGACY = 2'd0;
    localparam logic [1:0] MODE_SHORT  = 2'd1;

    typedef struct packed {
        logic              started;
        logic [CYC_W-1:0]  cyc;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        slave;
        logic              changed;
    } core_t;

    function automatic logic is_ack(input logic [CYC_W-1:0] c);
        return (c == 6'd9) || (c == 6'd18) || (c == 6'd27);
    endfunction
endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
    parameter int EARLY_CLKS = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_c,
    output logic sda_c,
    output logic scl_p,
    output logic sda_p,
    output logic quiet
);
    localparam int CNT_W = $clog2(EARLY_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EARLY_CLKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // line registers carry no reset: they always track the pins
    always_ff @(posedge clk) begin
        scl_c <= scl_i;
        sda_c <= sda_i;
        scl_p <= scl_c;
        sda_p <= sda_c;
    end

    always_comb begin
        cnt_d = cnt_q;
        if ((scl_c != scl_p) || (sda_c != sda_p)) cnt_d = '0;
        else if (cnt_q != LIMIT)                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign quiet = (cnt_q == LIMIT);
endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic          bit_in,
    output logic [7:0]    rd_byte
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= {mem[idx][6:0], bit_in};
    end

    assign rd_byte = mem[idx];
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
    import tw_pkg::*;
#(
    parameter int MEM_AW     = 9,
    parameter int EARLY_CLKS = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       changed_o
);
    logic scl_c, sda_c, scl_p, sda_p, quiet;

    tw_line_sampler #(.EARLY_CLKS(EARLY_CLKS)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_c(scl_c), .sda_c(sda_c), .scl_p(scl_p), .sda_p(sda_p),
        .quiet(quiet)
    );

    core_t st_d, st_q;

    logic start_ev, stop_ev, rise_ev, fall_ev;
    logic legacy, short_m, rd_flag, early;
    logic wr_en;
    logic [MEM_AW-1:0] mem_idx;
    logic [7:0] rd_byte;
    logic [CYC_W-1:0] nc, ecyc, shift_c;
    logic [ADDR_W-1:0] sh_addr;

    tw_byte_store #(.AW(MEM_AW)) u_store (
        .clk(clk), .we(wr_en), .idx(mem_idx), .bit_in(sda_c), .rd_byte(rd_byte)
    );

    assign start_ev = scl_p & scl_c & sda_p & ~sda_c;
    assign stop_ev  = scl_p & scl_c & ~sda_p & sda_c;
    assign rise_ev  = st_q.started & ~scl_p & scl_c;
    assign fall_ev  = st_q.started & scl_p & ~scl_c;

    assign legacy  = (mode_i == MODE_LEGACY);
    assign short_m = (mode_i == MODE_SHORT);
    assign rd_flag = legacy ? st_q.addr[0] : st_q.slave[0];
    assign mem_idx = legacy ? MEM_AW'(st_q.addr[7:1]) : st_q.addr[MEM_AW-1:0];
    assign sh_addr = {st_q.addr[ADDR_W-2:0], sda_c};

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        nc    = st_q.cyc + 6'd1;
        if (start_ev) begin
            st_d.started = 1'b1;
            st_d.cyc     = '0;
        end else if (stop_ev) begin
            st_d.started = 1'b0;
        end else if (rise_ev) begin
            st_d.cyc = nc;
            if (legacy) begin
                if (nc == 6'd18) begin
                    st_d.cyc = 6'd9;
                    if (st_q.addr[0]) st_d.addr = {5'b0, st_q.addr[7:0] + 8'd2};
                end
            end else if (st_q.slave[0] && nc == 6'd18) begin
                st_d.cyc  = 6'd9;
                st_d.addr = st_q.addr + 1'b1;
            end else if (short_m && nc == 6'd27) begin
                st_d.cyc = 6'd18;
            end else if (nc == 6'd36) begin
                st_d.cyc = 6'd27;
            end
        end else if (fall_ev) begin
            if (legacy) begin
                if (st_q.cyc == 6'd9) begin
                    // acknowledge slot: nothing captured
                end else if (st_q.cyc > 6'd9) begin
                    if (!st_q.addr[0]) begin
                        wr_en = 1'b1;
                        if (st_q.cyc == 6'd17)
                            st_d.addr = {5'b0, st_q.addr[7:3], st_q.addr[2:1] + 2'd1, st_q.addr[0]};
                    end
                end else begin
                    st_d.addr = {5'b0, st_q.addr[6:0], sda_c};
                end
            end else begin
                if (is_ack(st_q.cyc)) begin
                    // acknowledge slot: nothing captured
                end else if ((!short_m && st_q.cyc > 6'd27) || (short_m && st_q.cyc > 6'd18)) begin
                    if (!st_q.slave[0]) begin
                        wr_en = 1'b1;
                        if (st_q.cyc == 6'd26 || st_q.cyc == 6'd35)
                            st_d.addr = {st_q.addr[12:4], st_q.addr[3:0] + 4'd1};
                    end
                end else if (st_q.cyc > 6'd9) begin
                    if (!st_q.slave[0]) begin
                        if (short_m && st_q.cyc == 6'd17)
                            st_d.addr = {2'b0, st_q.slave[3:1], sh_addr[7:0]};
                        else if (short_m)
                            st_d.addr = {5'b0, sh_addr[7:0]};
                        else
                            st_d.addr = sh_addr;
                    end
                end else begin
                    st_d.slave = {st_q.slave[6:0], sda_c};
                end
            end
        end
        if (wr_en) st_d.changed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign early   = ~scl_c & quiet;
    assign ecyc    = st_q.cyc + {5'b0, early};
    assign shift_c = 6'd17 - ecyc;

    always_comb begin
        sda_o = sda_c;
        if (st_q.started) begin
            if (is_ack(ecyc))
                sda_o = 1'b0;
            else if (ecyc > 6'd9 && ecyc < 6'd18 && rd_flag)
                sda_o = rd_byte[shift_c[2:0]];
        end
    end

    assign changed_o = st_q.changed;

    logic              started_q, rw_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [ADDR_W-1:0] addr_q;
    assign started_q = st_q.started;
    assign rw_q      = st_q.slave[0];
    assign cyc_q     = st_q.cyc;
    assign addr_q    = st_q.addr;
endmodule

// File: rtl/twowire_eeprom_checker.sv
module twowire_eeprom_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode_i,
    input logic        scl_i,
    input logic        sda_i,
    input logic        sda_o,
    input logic        changed_o,
    input logic        started,
    input logic        rw,
    input logic [5:0]  cyc,
    input logic [12:0] addr,
    input logic        start_ev,
    input logic        stop_ev,
    input logic        rise_ev,
    input logic        fall_ev
);
    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (started && cyc == 6'd0));

    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !started);

    assert_open_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !started |-> (sda_o == $past(sda_i)));

    assert_ack_low_R3: assert property (@(posedge clk) disable iff (rst)
        (started && $past(scl_i) && (cyc == 6'd9 || cyc == 6'd18 || cyc == 6'd27)) |-> !sda_o);

    assert_legacy_range_R6: assert property (@(posedge clk) disable iff (rst)
        (started && mode_i == 2'd0) |-> (cyc < 6'd18));

    assert_legacy_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (rise_ev && mode_i == 2'd0 && cyc == 6'd17 && addr[0])
        |=> (cyc == 6'd9 && addr[7:0] == $past(addr[7:0]) + 8'd2));

    assert_page_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (fall_ev && mode_i == 2'd1 && cyc == 6'd26 && !rw)
        |=> (addr[12:4] == $past(addr[12:4])));

    assert_changed_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        changed_o |=> changed_o);
endmodule

bind twowire_eeprom twowire_eeprom_checker u_chk (
    .clk(clk), .rst(rst), .mode_i(mode_i), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_o), .changed_o(changed_o), .started(started_q), .rw(rw_q),
    .cyc(cyc_q), .addr(addr_q), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
);

// File: tb/twowire_eeprom_bench.sv
`timescale 1ns/100ps
module twowire_eeprom_bench;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_o, changed;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twowire_eeprom u_twowire_eeprom (
        .clk(clk), .rst(rst), .mode_i(mode), .scl_i(scl), .sda_i(sda),
        .sda_o(sda_o), .changed_o(changed)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        scl = c;
        sda = d;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_start();
        step(1'b0, sda); step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        step(1'b0, sda); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic b);
        step(1'b0, sda); step(1'b0, b); step(1'b1, b);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        step(1'b0, sda); step(1'b0, 1'b1); step(1'b1, 1'b1);
        chk("R3 ack slot", sda_o, 0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit last);
        for (int i = 7; i >= 0; i--) begin
            step(1'b0, sda); step(1'b0, 1'b1); step(1'b1, 1'b1);
            v[i] = sda_o;
        end
        step(1'b0, 1'b1); step(1'b0, last); step(1'b1, last);
    endtask

    task automatic wr_legacy(input logic [6:0] idx, input logic [7:0] d [8], input int n);
        do_start();
        send_byte({idx, 1'b0});
        for (int k = 0; k < n; k++) send_byte(d[k]);
        do_stop();
    endtask

    task automatic rd_legacy(input string req, input logic [6:0] idx,
                             input logic [7:0] e [8], input int n);
        logic [7:0] v;
        do_start();
        send_byte({idx, 1'b1});
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k == n - 1);
            chk(req, v, e[k]);
        end
        do_stop();
    endtask

    task automatic set_addr(input logic [15:0] a);
        if (mode == 2'd1) begin
            send_byte({4'b1010, a[10:8], 1'b0});
            send_byte(a[7:0]);
        end else begin
            send_byte({4'b1010, 3'b000, 1'b0});
            send_byte(a[15:8]);
            send_byte(a[7:0]);
        end
    endtask

    task automatic wr_dev(input logic [15:0] a, input logic [7:0] d [8], input int n);
        do_start();
        set_addr(a);
        for (int k = 0; k < n; k++) send_byte(d[k]);
        do_stop();
    endtask

    task automatic rd_dev(input string req, input logic [15:0] a,
                          input logic [7:0] e [8], input int n);
        logic [7:0] v;
        do_start();
        set_addr(a);
        do_start();
        send_byte({4'b1010, a[10:8], 1'b1});
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k == n - 1);
            chk(req, v, e[k]);
        end
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state and open bus
        chk("R1 changed after reset", changed, 0);
        chk("R1 sda_o idle", sda_o, 1);
        step(1'b0, 1'b0);
        chk("R2 open bus low", sda_o, 0);
        step(1'b0, 1'b1);
        chk("R2 open bus high", sda_o, 1);
        // R2: clock pulses with no start write nothing
        for (int i = 0; i < 18; i++) send_bit(1'b0);
        chk("R2 no write without start", changed, 0);

        // legacy mode
        mode = 2'd0;
        wr_legacy(7'd5, '{8'hA5, 8'h3C, 0, 0, 0, 0, 0, 0}, 2);
        chk("R12 changed after write", changed, 1);
        rd_legacy("R4 legacy readback", 7'd5, '{8'hA5, 8'h3C, 0, 0, 0, 0, 0, 0}, 2);
        wr_legacy(7'd10, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 0, 0, 0}, 5);
        rd_legacy("R5 group wrap", 7'd8, '{8'h33, 8'h44, 8'h55, 8'h22, 0, 0, 0, 0}, 4);
        wr_legacy(7'd127, '{8'h77, 0, 0, 0, 0, 0, 0, 0}, 1);
        wr_legacy(7'd0, '{8'h99, 0, 0, 0, 0, 0, 0, 0}, 1);
        rd_legacy("R6 index wraps mod 128", 7'd127, '{8'h77, 8'h99, 0, 0, 0, 0, 0, 0}, 2);

        // R11: early read after a quiet low clock line
        do_start();
        send_byte({7'd5, 1'b1});
        step(1'b0, 1'b1);
        chk("R11 short low keeps ack", sda_o, 0);
        repeat (40) @(negedge clk);
        chk("R11 early bit7", sda_o, 1);
        step(1'b1, 1'b1);
        chk("R6 bit7 at cycle 10", sda_o, 1);
        step(1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk("R11 early bit6", sda_o, 0);
        step(1'b1, 1'b1);
        do_stop();

        // short mode
        mode = 2'd1;
        wr_dev(16'h01C5, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, 1);
        wr_dev(16'h00C5, '{8'hC3, 0, 0, 0, 0, 0, 0, 0}, 1);
        rd_dev("R7 block 1", 16'h01C5, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, 1);
        rd_dev("R7 block 0", 16'h00C5, '{8'hC3, 0, 0, 0, 0, 0, 0, 0}, 1);
        wr_dev(16'h0020, '{8'hEE, 0, 0, 0, 0, 0, 0, 0}, 1);
        wr_dev(16'h001F, '{8'h01, 8'h02, 8'h03, 0, 0, 0, 0, 0}, 3);
        rd_dev("R9 page wrap short", 16'h0010, '{8'h02, 8'h03, 0, 0, 0, 0, 0, 0}, 2);
        rd_dev("R10 read crosses page", 16'h001F, '{8'h01, 8'hEE, 0, 0, 0, 0, 0, 0}, 2);

        // long mode
        mode = 2'd2;
        wr_dev(16'h01F0, '{8'hAB, 8'hCD, 0, 0, 0, 0, 0, 0}, 2);
        rd_dev("R8 two address bytes", 16'h01F0, '{8'hAB, 8'hCD, 0, 0, 0, 0, 0, 0}, 2);
        wr_dev(16'h01FF, '{8'h12, 8'h34, 0, 0, 0, 0, 0, 0}, 2);
        rd_dev("R9 page wrap long", 16'h01F0, '{8'h34, 0, 0, 0, 0, 0, 0, 0}, 1);
        rd_dev("R10 read crosses storage end", 16'h01FF, '{8'h12, 8'h99, 0, 0, 0, 0, 0, 0}, 2);
        rd_dev("R8 high bits masked", 16'hE1C5, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, 1);

        // R1/R12: reset clears flag, keeps contents; reads do not set it
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 changed cleared by reset", changed, 0);
        mode = 2'd1;
        rd_dev("R1 contents kept", 16'h01C5, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, 1);
        chk("R12 read leaves flag low", changed, 0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R2 open bus after stop", sda_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule